// File: doc/BRIEF.md
# Outlier-Victim Pair Codec

This block packs a stream of signed value pairs into one byte per pair. Each pair is cut down to two 4-bit fields. Ordinary values (inliers) are stored as saturated 4-bit two's-complement numbers. An element whose magnitude is above the effective threshold is an outlier, and it cannot be stored that way. Its partner in the pair is then dropped (the victim). The partner's nibble is replaced by a reserved marker code, and the outlier is re-coded into a small 4-bit sign/index floating format in the other nibble. Decoding depends only on the byte itself, so no side table and no indirection are needed.

On each cycle the input takes two raw signed values and a threshold, qualified by a valid strobe. One registered stage later the block presents the packed byte. It also presents a decoded copy of the pair, which is used for self-checking and for comparing reconstruction error. If both elements of a pair are outliers, the block falls back to keeping only the larger one.

Top module: `ovp_codec`

## Requirements
- R1: The byte holds element A in bits [3:0] and element B in bits [7:4]. An inlier is stored as its 4-bit two's-complement value.
- R2: An inlier is saturated to the range -7..+7, so the marker code 4'b1000 never comes from inlier data.
- R3: An element is an outlier when its magnitude is strictly greater than the effective threshold. The effective threshold is the threshold input, or 7 when the input is below 7.
- R4: When exactly one element is an outlier, the other element's nibble becomes the marker 4'b1000. The outlier's nibble holds its float code {sign, index}: bit 3 is the sign (1 = negative) and bits [2:0] hold an index from 1 to 7.
- R5: The index maps to the magnitudes 1:8, 2:12, 3:16, 4:24, 5:32, 6:48 and 7:64. The encoder picks the largest index whose magnitude does not exceed the input magnitude, which truncates toward zero.
- R6: When both elements are outliers, the one with the larger magnitude is kept and the other becomes the victim. On equal magnitudes, A is kept.
- R7: The decoder gives 0 for a victim position and the signed float magnitude for its partner. For a byte with no marker, it gives both nibbles sign-extended.
- R8: out_valid follows in_valid one clock later. out_byte is updated only on accepted input and holds its value otherwise.
- R9: While reset is active and until it is released, out_valid is 0 and out_byte is 0.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Qualifies the input pair |
| in_a | input | IN_W | Signed element A |
| in_b | input | IN_W | Signed element B |
| in_thr | input | IN_W | Unsigned outlier threshold |
| out_valid | output | 1 | Packed byte valid |
| out_byte | output | 8 | Packed pair |
| dec_a | output | IN_W | Signed decoded element A |
| dec_b | output | IN_W | Signed decoded element B |

## Verification
Pairs of small values test saturation and the two's-complement layout without any marker. Pairs with one large value show which slot is sacrificed and how float truncation works at each index boundary, including -128 and the clamp at 64. Pairs where both values are large, including pairs of equal magnitude, separate the rule that keeps the larger one from a rule that keeps A. Thresholds below 7, at 7 and well above it separate the clamped threshold from the raw one. A long random mix of these patterns, with gaps in valid, catches wrong hold behaviour.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
  localparam int NIB_W = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam logic [NIB_W-1:0] VICTIM_CODE = 4'b1000;
  localparam int INLIER_MAX = 7;
  localparam int FLT_IDX_MAX = 7;
  localparam int FLT_MIN_POW = 3;

  typedef struct packed {
    logic             outl;
    logic [NIB_W-1:0] inl_code;
    logic [NIB_W-1:0] flt_code;
  } lane_t;
endpackage

// File: rtl/ovp_lane_classify.sv
module ovp_lane_classify
  import ovp_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic [IN_W-1:0] x,
  input  logic [IN_W-1:0] thr,
  output lane_t           lane,
  output logic [IN_W-1:0] mag
);
  localparam logic [IN_W-1:0] INL_MAX_W = IN_W'(INLIER_MAX);

  logic            neg;
  logic [IN_W-1:0] eff_thr;
  logic [2:0]      smag;
  logic [2:0]      idx;

  always_comb begin
    neg     = x[IN_W-1];
    mag     = neg ? (~x + 1'b1) : x;
    eff_thr = (thr < INL_MAX_W) ? INL_MAX_W : thr;
    lane.outl = (mag > eff_thr);
    smag = (mag > INL_MAX_W) ? 3'(INLIER_MAX) : mag[2:0];
    lane.inl_code = neg ? (4'b0000 - {1'b0, smag}) : {1'b0, smag};
  end

  always_comb begin
    idx = 3'd1;
    for (int p = FLT_MIN_POW; p < IN_W; p++) begin
      if (mag[p]) begin
        if ((2 * (p - FLT_MIN_POW) + 1 + int'(mag[p-1])) > FLT_IDX_MAX)
          idx = 3'(FLT_IDX_MAX);
        else
          idx = 3'(2 * (p - FLT_MIN_POW) + 1 + int'(mag[p-1]));
      end
    end
    lane.flt_code = {neg, idx};
  end
endmodule

// File: rtl/ovp_pair_select.sv
module ovp_pair_select
  import ovp_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  lane_t             lane_a,
  input  lane_t             lane_b,
  input  logic [IN_W-1:0]   mag_a,
  input  logic [IN_W-1:0]   mag_b,
  output logic [BYTE_W-1:0] pair_byte,
  output logic              keep_a,
  output logic              keep_b
);
  always_comb begin
    keep_a = lane_a.outl && (!lane_b.outl || (mag_a >= mag_b));
    keep_b = lane_b.outl && !keep_a;
    if (keep_a)
      pair_byte = {VICTIM_CODE, lane_a.flt_code};
    else if (keep_b)
      pair_byte = {lane_b.flt_code, VICTIM_CODE};
    else
      pair_byte = {lane_b.inl_code, lane_a.inl_code};
  end
endmodule

// File: rtl/ovp_pair_decode.sv
module ovp_pair_decode
  import ovp_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic [BYTE_W-1:0] pair_byte,
  output logic [IN_W-1:0]   val_a,
  output logic [IN_W-1:0]   val_b
);
  function automatic logic [IN_W-1:0] flt_val(input logic [NIB_W-1:0] n);
    logic [2:0]      k;
    logic [IN_W-1:0] m;
    k = n[2:0] - 3'd1;
    m = {{(IN_W-2){1'b0}}, 1'b1, k[0]} << ({1'b0, k[2:1]} + 3'd2);
    if (n[2:0] == 3'd0) m = '0;
    return n[NIB_W-1] ? (~m + 1'b1) : m;
  endfunction

  function automatic logic [IN_W-1:0] sext(input logic [NIB_W-1:0] n);
    return {{(IN_W-NIB_W){n[NIB_W-1]}}, n};
  endfunction

  logic [NIB_W-1:0] lo, hi;

  always_comb begin
    lo = pair_byte[NIB_W-1:0];
    hi = pair_byte[BYTE_W-1:NIB_W];
    if (hi == VICTIM_CODE) begin
      val_a = flt_val(lo);
      val_b = '0;
    end else if (lo == VICTIM_CODE) begin
      val_a = '0;
      val_b = flt_val(hi);
    end else begin
      val_a = sext(lo);
      val_b = sext(hi);
    end
  end
endmodule

// File: rtl/ovp_codec.sv
module ovp_codec
  import ovp_pkg::*;
#(
  parameter int IN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_a,
  input  logic [IN_W-1:0]   in_b,
  input  logic [IN_W-1:0]   in_thr,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_byte,
  output logic [IN_W-1:0]   dec_a,
  output logic [IN_W-1:0]   dec_b
);
  localparam int LANES = 2;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  lane_t           lanes [LANES];
  logic [IN_W-1:0] mags  [LANES];
  logic [IN_W-1:0] raw   [LANES];

  assign raw[0] = in_a;
  assign raw[1] = in_b;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    ovp_lane_classify #(.IN_W(IN_W)) u_cls (
      .x    (raw[g]),
      .thr  (in_thr),
      .lane (lanes[g]),
      .mag  (mags[g])
    );
  end

  logic [BYTE_W-1:0] sel_byte;
  logic              keep_a, keep_b;

  ovp_pair_select #(.IN_W(IN_W)) u_sel (
    .lane_a    (lanes[0]),
    .lane_b    (lanes[1]),
    .mag_a     (mags[0]),
    .mag_b     (mags[1]),
    .pair_byte (sel_byte),
    .keep_a    (keep_a),
    .keep_b    (keep_b)
  );

  logic [BYTE_W-1:0] byte_q, byte_d;
  logic              vld_q, vld_d;

  always_comb begin
    vld_d  = in_valid;
    byte_d = in_valid ? sel_byte : byte_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q  <= 1'b0;
      byte_q <= '0;
    end else begin
      vld_q  <= vld_d;
      byte_q <= byte_d;
    end
  end

  assign out_valid = vld_q;
  assign out_byte  = byte_q;

  ovp_pair_decode #(.IN_W(IN_W)) u_dec (
    .pair_byte (byte_q),
    .val_a     (dec_a),
    .val_b     (dec_b)
  );

  AST_ONE_VICTIM: assert property (@(posedge clk) disable iff (!rst_int_n)
    out_valid |-> !((out_byte[7:4] == VICTIM_CODE) && (out_byte[3:0] == VICTIM_CODE))); // R4
  AST_KEEP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(keep_a && keep_b)); // R6
  AST_INLIER_NO_MARK: assert property (@(posedge clk) disable iff (!rst_int_n)
    (in_valid && !lanes[0].outl && !lanes[1].outl) |=>
      ((out_byte[7:4] != VICTIM_CODE) && (out_byte[3:0] != VICTIM_CODE))); // R2
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_int_n)
    in_valid |=> out_valid); // R8
  AST_HOLD_BYTE: assert property (@(posedge clk) disable iff (!rst_int_n)
    !in_valid |=> $stable(out_byte)); // R8
  AST_VICTIM_ZERO: assert property (@(posedge clk) disable iff (!rst_int_n)
    (out_byte[7:4] == VICTIM_CODE) |-> (dec_b == '0)); // R7
endmodule

// File: tb/ovp_codec_tb_top.sv
module ovp_codec_tb_top;
  localparam int IN_W = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic [IN_W-1:0] in_a, in_b, in_thr;
  logic            out_valid;
  logic [7:0]      out_byte;
  logic [IN_W-1:0] dec_a, dec_b;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ovp_codec #(.IN_W(IN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_thr(in_thr),
    .out_valid(out_valid), .out_byte(out_byte),
    .dec_a(dec_a), .dec_b(dec_b)
  );

  function automatic int fmag(input int idx);
    case (idx)
      1: return 8;  2: return 12; 3: return 16; 4: return 24;
      5: return 32; 6: return 48; 7: return 64;
      default: return 0;
    endcase
  endfunction

  function automatic int absv(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int sat7(input int v);
    return (v > 7) ? 7 : ((v < -7) ? -7 : v);
  endfunction

  function automatic int fidx(input int m);
    for (int i = 7; i >= 1; i--) if (fmag(i) <= m) return i;
    return 1;
  endfunction

  // expected byte and decoded pair from the requirements
  task automatic model(input int a, input int b, input int thr,
                       output logic [7:0] eb, output int da, output int db);
    int  et;
    bit  oa, ob, ka, kb;
    et = (thr < 7) ? 7 : thr;
    oa = absv(a) > et;
    ob = absv(b) > et;
    ka = oa && (!ob || absv(a) >= absv(b));
    kb = ob && !ka;
    if (ka) begin
      eb = {4'b1000, (a < 0) ? 1'b1 : 1'b0, 3'(fidx(absv(a)))};
      da = (a < 0) ? -fmag(fidx(absv(a))) : fmag(fidx(absv(a)));
      db = 0;
    end else if (kb) begin
      eb = {(b < 0) ? 1'b1 : 1'b0, 3'(fidx(absv(b))), 4'b1000};
      da = 0;
      db = (b < 0) ? -fmag(fidx(absv(b))) : fmag(fidx(absv(b)));
    end else begin
      eb = {4'(sat7(b)), 4'(sat7(a))};
      da = sat7(a);
      db = sat7(b);
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input int a, input int b, input int thr, input string req);
    logic [7:0] eb;
    int da, db;
    model(a, b, thr, eb, da, db);
    in_valid = 1'b1;
    in_a = IN_W'(a); in_b = IN_W'(b); in_thr = IN_W'(thr);
    @(negedge clk);
    check({req, " R8 valid"}, int'(out_valid), 1);
    check({req, " byte"}, int'(out_byte), int'(eb));
    check({req, " R7 dec_a"}, int'($signed(dec_a)), da);
    check({req, " R7 dec_b"}, int'($signed(dec_b)), db);
  endtask

  task automatic idle(input int a, input int b);
    logic [7:0] keep;
    keep = out_byte;
    in_valid = 1'b0;
    in_a = IN_W'(a); in_b = IN_W'(b); in_thr = 0;
    @(negedge clk);
    check("R8 idle valid", int'(out_valid), 0);
    check("R8 idle hold", int'(out_byte), int'(keep));
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h0C0DE5));
    rst_n = 1'b0; in_valid = 1'b0; in_a = '0; in_b = '0; in_thr = '0;
    repeat (3) @(negedge clk);
    check("R9 reset valid", int'(out_valid), 0);
    check("R9 reset byte", int'(out_byte), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R9 after release", int'(out_valid), 0);

    send(3, -5, 0, "R1");
    check("R1 layout", int'(out_byte), 8'hB3);
    send(-7, 7, 7, "R1 edges");
    send(100, -100, 120, "R2 sat");
    check("R2 sat byte", int'(out_byte), 8'h97);
    send(8, 2, 3, "R3 low thr");
    send(8, 2, 8, "R3 at thr");
    send(9, 2, 8, "R3 above");
    send(1, -12, 0, "R4 b outlier");
    check("R4 marker low", int'(out_byte), 8'hA8);
    send(-128, 0, 0, "R5 clamp");
    send(63, 0, 0, "R5 trunc");
    send(47, 0, 0, "R5 idx5");
    send(-15, 0, 0, "R5 idx2");
    send(20, -30, 0, "R6 b larger");
    send(-40, 40, 0, "R6 tie");
    send(-8, -8, 0, "R6 tie neg");
    idle(90, 90);
    idle(-3, 4);

    for (int n = 0; n < 600; n++) begin
      int a, b, t, sel;
      sel = int'($urandom_range(0, 3));
      a = int'($urandom_range(0, 255)) - 128;
      b = int'($urandom_range(0, 255)) - 128;
      if (sel == 0) begin a = a / 16; b = b / 16; end
      t = (sel == 1) ? int'($urandom_range(0, 127)) : int'($urandom_range(0, 12));
      send(a, b, t, "R6 random");
      if ($urandom_range(0, 7) == 0) idle(b, a);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule